// File: doc/BRIEF.md
# Power Management Event Register File

This block is a 64-byte bank of power-management registers on a byte-wide access port. It holds status and enable words, combines them into a system control interrupt, and builds a summary byte from several status sources. A bus front end issues each access as byte strobes. A 16-bit or 32-bit access becomes two or four strobes at consecutive offsets, lowest offset first. Status words are cleared by writing ones. Enable words keep only their writable bits. Hardware event strobes set status bits directly.

The interrupt is a level signal. A mode input sends it either to a PCI INTx pin output or to the legacy IRQ9 line output, and the unselected output stays low. Read data is combinational from the current byte offset. A write takes effect at the clock edge that samples it.

Top module: `pm_evt_regfile`

## Requirements
- R1: After reset the power-button status bit (bit 8 of PM status) is 1, so offset 0x01 reads 0x01. All other stored bits are 0. The interrupt outputs are low.
- R2: Each byte write changes only the byte lane at its own offset (lane = offset modulo the register width in bytes). The other lanes of the same register keep their values.
- R3: PM status (offsets 0x00 low byte, 0x01 high byte) is write-one-to-clear. Only bits in mask 0x8d31 can be cleared or set.
- R4: PM enable (offsets 0x02, 0x03) stores written data ANDed with mask 0x0521.
- R5: The interrupt is active while (PM status AND PM enable) has bit 10, 8, 5 or 0 set, and inactive otherwise. It follows the registers from the cycle after a write or event strobe.
- R6: With `irq_mode`=1 the interrupt appears on `sci_intx` and `sci_irq9` is 0. With `irq_mode`=0 it appears on `sci_irq9` and `sci_intx` is 0.
- R7: Offset 0x18 reads the stored global status bits ANDed with 0x05, plus the following flags: bit 7 if general-purpose status is nonzero, bit 6 if PM status is nonzero, bit 5 if `smm_active` is high, bit 4 if device status is nonzero. Offset 0x19 reads stored bits 15:8. Global status is write-one-to-clear with mask 0x0df7.
- R8: Device status (0x1c..0x1f, 32 bits) always reads bit 28 as 1, which is bit 4 of offset 0x1f. It is write-one-to-clear with mask 0x3fff0fff.
- R9: General-purpose status (0x0c, 0x0d) is write-one-to-clear with mask 0x0f81. General-purpose enable (0x0e, 0x0f) keeps mask 0x0f01. Global enable (0x20, 0x21) keeps mask 0x8d1f.
- R10: A set-input bit of any status register, within that register's mask, sets the stored bit. When a set and a write-one-clear of the same bit land in the same cycle, the set wins.
- R11: Reads from any offset not listed above return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Byte write strobe qualifier |
| acc_write | input | 1 | 1 = write the byte at `acc_addr` |
| acc_addr | input | 6 | Byte offset in the window |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for `acc_addr` (combinational) |
| pm_set | input | 16 | PM status set strobes |
| gp_set | input | 16 | General-purpose status set strobes |
| glb_set | input | 16 | Global status set strobes |
| dev_set | input | 32 | Device status set strobes |
| smm_active | input | 1 | Management-mode flag shown in global status |
| irq_mode | input | 1 | 1 = PCI INTx routing, 0 = IRQ9 routing |
| sci_intx | output | 1 | Interrupt on PCI INTx pin |
| sci_irq9 | output | 1 | Interrupt on legacy IRQ9 line |

## Verification
An event strobe and a software clear can hit the same PM status bit in the same cycle. The bench provokes this by driving `pm_set` bit 0 in the same cycle as a write of 0x01 to offset 0x00. It then requires the bit to read back as 1, because a lost timer-overflow event would be a silent failure. A second collision is between the interrupt level and a clearing write. The bench arms the enables, clears the only pending cause, and checks that the routed output drops in the very next cycle while a surviving cause keeps it high.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   localparam logic [15:0] PM_STS_MASK  = 16'h8d31;
   localparam logic [15:0] PM_STS_RST   = 16'h0100;
   localparam logic [15:0] PM_EN_MASK   = 16'h0521;
   localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
   localparam logic [15:0] GP_STS_MASK  = 16'h0f81;
   localparam logic [15:0] GP_EN_MASK   = 16'h0f01;
   localparam logic [15:0] GLB_STS_MASK = 16'h0df7;
   localparam logic [15:0] GLB_EN_MASK  = 16'h8d1f;
   localparam logic [31:0] DEV_STS_MASK = 32'h3fff0fff;
   localparam logic [31:0] DEV_RD_FORCE = 32'h10000000;
   localparam logic [7:0]  GLB_LO_KEEP  = 8'h05;

   // word-aligned offsets (bits 5:1 for 16-bit, 5:2 for 32-bit words)
   localparam logic [4:0] OFS_PM_STS  = 5'h00;
   localparam logic [4:0] OFS_PM_EN   = 5'h01;
   localparam logic [4:0] OFS_GP_STS  = 5'h06;
   localparam logic [4:0] OFS_GP_EN   = 5'h07;
   localparam logic [4:0] OFS_GLB_STS = 5'h0c;
   localparam logic [3:0] OFS_DEV_STS = 4'h7;
   localparam logic [4:0] OFS_GLB_EN  = 5'h10;

   typedef enum logic {REG_RW = 1'b0, REG_W1C = 1'b1} reg_kind_e;
endpackage

// File: rtl/pm_lane_reg.sv
module pm_lane_reg
   import pm_evt_pkg::*;
#(
   parameter int        W       = 16,
   parameter logic [W-1:0] MASK = '1,
   parameter logic [W-1:0] RST  = '0,
   parameter reg_kind_e KIND    = REG_RW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   lane,
   input  logic [7:0]   wdata,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] q
);
   localparam int LN = W / 8;
   localparam int LW = (LN > 1) ? $clog2(LN) : 1;

   if (W % 8 != 0 || LN < 2 || LN > 4) begin : g_bad_width
      $error("pm_lane_reg: W must be 16 or 32");
   end

   logic [W-1:0] lane_sel;
   logic [W-1:0] lane_data;

   for (genvar l = 0; l < LN; l++) begin : g_lane
      assign lane_sel[l*8 +: 8]  = (wr_en && lane[LW-1:0] == LW'(l)) ? 8'hff : 8'h00;
      assign lane_data[l*8 +: 8] = wdata;
   end

   logic [W-1:0] q_nxt;

   if (KIND == REG_W1C) begin : g_w1c
      // set strobes override a clear of the same bit
      assign q_nxt = ((q & ~(lane_sel & lane_data)) | set_bits) & MASK;
   end else begin : g_rw
      assign q_nxt = ((q & ~lane_sel) | (lane_data & lane_sel)) & MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/pm_sci_route.sv
module pm_sci_route (
   input  logic level,
   input  logic irq_mode,
   output logic sci_intx,
   output logic sci_irq9
);
   assign sci_intx = level &  irq_mode;
   assign sci_irq9 = level & ~irq_mode;
endmodule

// File: rtl/pm_evt_regfile.sv
module pm_evt_regfile
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic [7:0]        acc_rdata,
   input  logic [15:0]       pm_set,
   input  logic [15:0]       gp_set,
   input  logic [15:0]       glb_set,
   input  logic [31:0]       dev_set,
   input  logic              smm_active,
   input  logic              irq_mode,
   output logic              sci_intx,
   output logic              sci_irq9
);
   if (ADDR_W != 6) begin : g_bad_addr
      $error("pm_evt_regfile: window is 64 bytes, ADDR_W must be 6");
   end

   logic       wr;
   logic [4:0] w16;
   logic [3:0] w32;
   assign wr  = acc_valid & acc_write;
   assign w16 = acc_addr[5:1];
   assign w32 = acc_addr[5:2];

   logic [15:0] pm_sts_q, pm_en_q, gp_sts_q, gp_en_q, glb_sts_q, glb_en_q;
   logic [31:0] dev_sts_q;

   pm_lane_reg #(.W(16), .MASK(PM_STS_MASK), .RST(PM_STS_RST), .KIND(REG_W1C)) u_pm_sts (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_PM_STS), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(pm_set & PM_STS_MASK), .q(pm_sts_q));

   pm_lane_reg #(.W(16), .MASK(PM_EN_MASK), .RST(16'h0000), .KIND(REG_RW)) u_pm_en (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_PM_EN), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(16'h0000), .q(pm_en_q));

   pm_lane_reg #(.W(16), .MASK(GP_STS_MASK), .RST(16'h0000), .KIND(REG_W1C)) u_gp_sts (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_GP_STS), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(gp_set & GP_STS_MASK), .q(gp_sts_q));

   pm_lane_reg #(.W(16), .MASK(GP_EN_MASK), .RST(16'h0000), .KIND(REG_RW)) u_gp_en (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_GP_EN), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(16'h0000), .q(gp_en_q));

   pm_lane_reg #(.W(16), .MASK(GLB_STS_MASK), .RST(16'h0000), .KIND(REG_W1C)) u_glb_sts (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_GLB_STS), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(glb_set & GLB_STS_MASK), .q(glb_sts_q));

   pm_lane_reg #(.W(32), .MASK(DEV_STS_MASK), .RST(32'h0), .KIND(REG_W1C)) u_dev_sts (
      .clk, .rst_n, .wr_en(wr && w32 == OFS_DEV_STS), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(dev_set & DEV_STS_MASK), .q(dev_sts_q));

   pm_lane_reg #(.W(16), .MASK(GLB_EN_MASK), .RST(16'h0000), .KIND(REG_RW)) u_glb_en (
      .clk, .rst_n, .wr_en(wr && w16 == OFS_GLB_EN), .lane(acc_addr[1:0]),
      .wdata(acc_wdata), .set_bits(16'h0000), .q(glb_en_q));

   // composed summary byte for the low half of global status
   logic [7:0] glb_lo_rd;
   assign glb_lo_rd = (glb_sts_q[7:0] & GLB_LO_KEEP)
                    | {(|gp_sts_q), (|pm_sts_q), smm_active, (|dev_sts_q), 4'h0};

   logic [31:0] dev_rd;
   assign dev_rd = dev_sts_q | DEV_RD_FORCE;

   always_comb begin
      acc_rdata = 8'h00;
      if (w16 == OFS_PM_STS)       acc_rdata = acc_addr[0] ? pm_sts_q[15:8]  : pm_sts_q[7:0];
      else if (w16 == OFS_PM_EN)   acc_rdata = acc_addr[0] ? pm_en_q[15:8]   : pm_en_q[7:0];
      else if (w16 == OFS_GP_STS)  acc_rdata = acc_addr[0] ? gp_sts_q[15:8]  : gp_sts_q[7:0];
      else if (w16 == OFS_GP_EN)   acc_rdata = acc_addr[0] ? gp_en_q[15:8]   : gp_en_q[7:0];
      else if (w16 == OFS_GLB_STS) acc_rdata = acc_addr[0] ? glb_sts_q[15:8] : glb_lo_rd;
      else if (w32 == OFS_DEV_STS) acc_rdata = dev_rd[acc_addr[1:0]*8 +: 8];
      else if (w16 == OFS_GLB_EN)  acc_rdata = acc_addr[0] ? glb_en_q[15:8]  : glb_en_q[7:0];
   end

   logic sci_level;
   assign sci_level = |(pm_sts_q & pm_en_q & SCI_SRC_MASK);

   pm_sci_route u_route (
      .level(sci_level), .irq_mode(irq_mode),
      .sci_intx(sci_intx), .sci_irq9(sci_irq9));
endmodule

// File: rtl/pm_evt_regfile_chk.sv
module pm_evt_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_write,
   input logic [5:0]  acc_addr,
   input logic [7:0]  acc_wdata,
   input logic [7:0]  acc_rdata,
   input logic [15:0] pm_set,
   input logic        irq_mode,
   input logic        sci_intx,
   input logic        sci_irq9,
   input logic [15:0] pm_sts_q,
   input logic [15:0] pm_en_q
);
   assert_route_intx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mode |-> !sci_irq9);
   assert_route_irq9_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mode |-> !sci_intx);

   assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 6'h00 && pm_set == 16'h0)
      |=> ((pm_sts_q[7:0] & $past(acc_wdata) & 8'h31) == 8'h00));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pm_set[0] |=> pm_sts_q[0]);

   assert_en_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 6'h02)
      |=> (pm_en_q[7:0] == ($past(acc_wdata) & 8'h21)));

   assert_sci_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sci_intx || sci_irq9)
      |-> ($past(|pm_set) || $past(acc_valid && acc_write && acc_addr[5:1] == 5'h01)));

   assert_unimpl_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr == 6'h3f) |-> (acc_rdata == 8'h00));

   assert_dev_bit28_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr == 6'h1f) |-> acc_rdata[4]);
endmodule

bind pm_evt_regfile pm_evt_regfile_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
   .pm_set(pm_set), .irq_mode(irq_mode), .sci_intx(sci_intx), .sci_irq9(sci_irq9),
   .pm_sts_q(pm_sts_q), .pm_en_q(pm_en_q));

// File: tb/pm_evt_regfile_bench.sv
module pm_evt_regfile_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [5:0]  acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  acc_rdata;
   logic [15:0] pm_set = '0, gp_set = '0, glb_set = '0;
   logic [31:0] dev_set = '0;
   logic        smm_active = 1'b0, irq_mode = 1'b0;
   logic        sci_intx, sci_irq9;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pm_evt_regfile u_pm_evt_regfile (
      .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata, .acc_rdata,
      .pm_set, .gp_set, .glb_set, .dev_set, .smm_active, .irq_mode,
      .sci_intx, .sci_irq9);

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic chk_rd(input string req, input logic [5:0] a, input logic [7:0] exp);
      acc_addr = a;
      #1;
      checks++;
      if (acc_rdata !== exp) begin
         failures++;
         $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, a, acc_rdata, exp);
      end
   endtask

   task automatic chk_sci(input string req, input logic ex_intx, input logic ex_irq9);
      #1;
      checks++;
      if (sci_intx !== ex_intx || sci_irq9 !== ex_irq9) begin
         failures++;
         $display("FAIL %s actual intx=%0b irq9=%0b expected intx=%0b irq9=%0b",
                  req, sci_intx, sci_irq9, ex_intx, ex_irq9);
      end
   endtask

   task automatic t_reset_R1;
      @(negedge clk);
      chk_rd("R1", 6'h00, 8'h00);
      chk_rd("R1", 6'h01, 8'h01);
      chk_rd("R1", 6'h02, 8'h00);
      chk_rd("R1", 6'h1c, 8'h00);
      chk_rd("R7", 6'h18, 8'h40);   // PM status nonzero flag after reset
      chk_sci("R1", 1'b0, 1'b0);
   endtask

   task automatic t_enable_route_R4_R6;
      wr(6'h02, 8'hff);
      chk_rd("R4", 6'h02, 8'h21);
      chk_rd("R2", 6'h03, 8'h00);
      wr(6'h03, 8'hff);
      chk_rd("R4", 6'h03, 8'h05);
      chk_sci("R5", 1'b0, 1'b1);    // power button pending, IRQ9 route
      irq_mode = 1'b1;
      chk_sci("R6", 1'b1, 1'b0);
   endtask

   task automatic t_pm_w1c_R3;
      wr(6'h01, 8'hff);
      chk_rd("R3", 6'h01, 8'h00);
      chk_sci("R5", 1'b0, 1'b0);
      @(negedge clk); pm_set = 16'hffff;
      @(negedge clk); pm_set = 16'h0000;
      chk_rd("R3", 6'h00, 8'h31);
      chk_rd("R3", 6'h01, 8'h8d);
      wr(6'h00, 8'h01);             // clear timer overflow only
      chk_rd("R3", 6'h00, 8'h30);
      chk_rd("R2", 6'h01, 8'h8d);
      chk_sci("R5", 1'b1, 1'b0);    // global, rtc, button still pending
      wr(6'h00, 8'hff);
      wr(6'h01, 8'hff);
      chk_sci("R5", 1'b0, 1'b0);
      chk_rd("R3", 6'h00, 8'h00);
   endtask

   task automatic t_collision_R10;
      @(negedge clk);
      pm_set = 16'h0001;
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 6'h00; acc_wdata = 8'h01;
      @(negedge clk);
      pm_set = 16'h0000; acc_valid = 1'b0; acc_write = 1'b0;
      chk_rd("R10", 6'h00, 8'h01);
      chk_sci("R10", 1'b1, 1'b0);
      wr(6'h00, 8'h01);
      chk_sci("R5", 1'b0, 1'b0);
   endtask

   task automatic t_global_R7;
      smm_active = 1'b1;
      @(negedge clk); gp_set = 16'hffff; glb_set = 16'hffff;
      @(negedge clk); gp_set = 16'h0; glb_set = 16'h0;
      chk_rd("R7", 6'h18, 8'ha5);
      chk_rd("R7", 6'h19, 8'h0d);
      wr(6'h18, 8'hff);
      chk_rd("R7", 6'h18, 8'ha0);
      smm_active = 1'b0;
      chk_rd("R7", 6'h18, 8'h80);
   endtask

   task automatic t_gp_R9;
      chk_rd("R9", 6'h0c, 8'h81);
      chk_rd("R9", 6'h0d, 8'h0f);
      wr(6'h0c, 8'h80);
      chk_rd("R9", 6'h0c, 8'h01);
      wr(6'h0c, 8'hff); wr(6'h0d, 8'hff);
      chk_rd("R9", 6'h18, 8'h00);
      wr(6'h0e, 8'hff); wr(6'h0f, 8'hff);
      chk_rd("R9", 6'h0e, 8'h01);
      chk_rd("R9", 6'h0f, 8'h0f);
      wr(6'h20, 8'hff); wr(6'h21, 8'hff);
      chk_rd("R9", 6'h20, 8'h1f);
      chk_rd("R9", 6'h21, 8'h8d);
   endtask

   task automatic t_dev_R8;
      chk_rd("R8", 6'h1f, 8'h10);
      @(negedge clk); dev_set = 32'hffffffff;
      @(negedge clk); dev_set = 32'h0;
      chk_rd("R8", 6'h1c, 8'hff);
      chk_rd("R8", 6'h1d, 8'h0f);
      chk_rd("R8", 6'h1e, 8'hff);
      chk_rd("R8", 6'h1f, 8'h3f);
      chk_rd("R7", 6'h18, 8'h10);
      wr(6'h1f, 8'hff);
      chk_rd("R8", 6'h1f, 8'h10);
      chk_rd("R2", 6'h1e, 8'hff);
   endtask

   task automatic t_unimpl_R11;
      chk_rd("R11", 6'h04, 8'h00);
      chk_rd("R11", 6'h14, 8'h00);
      chk_rd("R11", 6'h3f, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_R1();
      t_enable_route_R4_R6();
      t_pm_w1c_R3();
      t_collision_R10();
      t_global_R7();
      t_gp_R9();
      t_dev_R8();
      t_unimpl_R11();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule